// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block hands out 4-bit memory allocation tags on request. A 24-bit state register holds a 16-bit pseudo-random seed and the last tag issued. In random mode a request steps the seed four times through a linear feedback shift register. The four bits this yields form an offset. The block then advances that many times from the stored tag, through tag values only, skipping any value that is excluded. It returns the tag it reaches and writes the chosen tag and the advanced seed back into the state register.

In add mode the start tag and the offset come straight from the request. The same exclusion walk runs, and the state register is left untouched. The set of excluded tags is the OR of a per-request mask and a global mask. The search is sequential and takes one cycle per increment. While it runs the block reports busy and refuses new requests. A one-cycle done strobe marks the result.

Top module: `tag_pick_unit`

## Requirements
- R1: After reset, `state_o`, `tag_o`, `busy_o` and `done_o` are all zero.
- R2: When idle and no request is accepted in the same cycle, `st_wr_i` loads `state_o` from `st_wdata_i` with bits [7:4] cleared. The start tag sits in bits [3:0] and the seed in bits [23:8]. A write while busy is ignored.
- R3: The excluded set is `excl_req_i | excl_glb_i`, sampled when the request is accepted; bit k set excludes tag k. Unless every tag is excluded, the returned tag is never excluded.
- R4: If all 16 tags are excluded, the result is tag 0.
- R5: In random mode (`mode_i`=0) the offset comes from four seed steps. Each step takes the XOR of seed bits 5, 3, 2 and 0 as its new bit, shifts the seed right by one and inserts that bit at bit 15. The bit from step i is offset bit i.
- R6: With offset 0, the tag starts at the start tag and increments modulo 16 while the current value is excluded.
- R7: With offset N>0, the block makes N advances. Each advance increments modulo 16 once and keeps incrementing while the value is excluded.
- R8: When a random-mode request completes, `state_o` becomes the chosen tag in [3:0], zeros in [7:4] and the advanced seed in [23:8]. Its start tag is `state_o[3:0]`.
- R9: In add mode (`mode_i`=1) the start tag is `add_start_i` and the offset is `add_ofs_i`. `state_o` is unchanged by the request.
- R10: A request raised while `busy_o` is high is refused and does not change the result or the state.
- R11: `busy_o` is high from the cycle after acceptance until the result. `done_o` is a one-cycle pulse with `busy_o` low, and `tag_o` holds the result. The search lasts at most 16 cycles per advance plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, accepted when not busy |
| mode_i | input | 1 | 0 random, 1 add |
| excl_req_i | input | 16 | Per-request excluded tags |
| excl_glb_i | input | 16 | Global excluded tags |
| add_start_i | input | 4 | Start tag for add mode |
| add_ofs_i | input | 4 | Tag offset for add mode |
| st_wr_i | input | 1 | State register write strobe |
| st_wdata_i | input | 24 | State register write data |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result strobe |
| tag_o | output | 4 | Chosen tag |
| state_o | output | 24 | State register (tag, seed) |

## Verification
The checker takes the exclusion mask and mode as they stand at an accepted request and assumes nothing about them afterwards. It relies on `req_i` being sampled only when `busy_o` is low, and it bounds each search by advance count times tag count. The stimulus changes inputs only between clock edges. It mixes empty, sparse, dense, single-hole and full masks, so short and maximum-length walks both occur. It also raises requests and state writes during a long search, to show they are refused.

// File: rtl/tagpick_pkg.sv
package tagpick_pkg;

    // feedback taps of the seed register: bits 5, 3, 2, 0
    localparam logic [15:0] FB_TAPS = 16'h002D;

    typedef enum logic {
        PICK_RAND = 1'b0,
        PICK_ADD  = 1'b1
    } pick_mode_e;

endpackage

// File: rtl/tagpick_lfsr.sv
module tagpick_lfsr #(
    parameter int                SEED_W = 16,
    parameter int                OFS_W  = 4,
    parameter logic [SEED_W-1:0] TAPS   = SEED_W'(tagpick_pkg::FB_TAPS)
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [OFS_W-1:0]  ofs_o
);

    logic [SEED_W-1:0] chain [OFS_W+1];

    assign chain[0] = seed_i;

    for (genvar g = 0; g < OFS_W; g++) begin : g_step
        logic fb;
        assign fb           = ^(chain[g] & TAPS);
        assign chain[g + 1] = {fb, chain[g][SEED_W-1:1]};
        assign ofs_o[g]     = fb;
    end

    assign seed_o = chain[OFS_W];

endmodule

// File: rtl/tagpick_search.sv
module tagpick_search #(
    parameter int TAG_W = 4,
    parameter int OFS_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [TAG_W-1:0]      start_tag_i,
    input  logic [OFS_W-1:0]      ofs_i,
    input  logic [(1<<TAG_W)-1:0] mask_i,
    output logic                  busy_o,
    output logic                  fin_o,
    output logic [TAG_W-1:0]      fin_tag_o,
    output logic                  done_o,
    output logic [TAG_W-1:0]      tag_o
);

    localparam int NTAGS = 1 << TAG_W;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [TAG_W-1:0] cur;
        logic [OFS_W-1:0] left;
        logic [NTAGS-1:0] mask;
        logic [TAG_W-1:0] tag;
    } srch_s;

    srch_s            s_d, s_q;
    logic [TAG_W-1:0] step_tag;
    logic             fin;
    logic [TAG_W-1:0] fin_tag;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        step_tag = s_q.cur + 1'b1;
        fin      = 1'b0;
        fin_tag  = '0;
        if (s_q.busy) begin
            if (&s_q.mask) begin
                fin     = 1'b1;
                fin_tag = '0;
            end else if (s_q.left == '0) begin
                if (s_q.mask[s_q.cur]) begin
                    s_d.cur = step_tag;
                end else begin
                    fin     = 1'b1;
                    fin_tag = s_q.cur;
                end
            end else begin
                s_d.cur = step_tag;
                if (!s_q.mask[step_tag]) begin
                    s_d.left = s_q.left - 1'b1;
                    if (s_q.left == OFS_W'(1)) begin
                        fin     = 1'b1;
                        fin_tag = step_tag;
                    end
                end
            end
            if (fin) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.tag  = fin_tag;
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cur  = start_tag_i;
            s_d.left = ofs_i;
            s_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = s_q.busy;
    assign fin_o     = fin;
    assign fin_tag_o = fin_tag;
    assign done_o    = s_q.done;
    assign tag_o     = s_q.tag;

endmodule

// File: rtl/tag_pick_unit.sv
module tag_pick_unit #(
    parameter int TAG_W    = 4,
    parameter int OFS_W    = 4,
    parameter int SEED_W   = 16,
    parameter int SEED_LSB = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic                         mode_i,
    input  logic [(1<<TAG_W)-1:0]        excl_req_i,
    input  logic [(1<<TAG_W)-1:0]        excl_glb_i,
    input  logic [TAG_W-1:0]             add_start_i,
    input  logic [OFS_W-1:0]             add_ofs_i,
    input  logic                         st_wr_i,
    input  logic [SEED_LSB+SEED_W-1:0]   st_wdata_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [TAG_W-1:0]             tag_o,
    output logic [SEED_LSB+SEED_W-1:0]   state_o
);

    import tagpick_pkg::*;

    localparam int NTAGS   = 1 << TAG_W;
    localparam int STATE_W = SEED_LSB + SEED_W;
    localparam int GAP_W   = SEED_LSB - TAG_W;
    localparam logic [STATE_W-1:0] WR_MASK =
        {{SEED_W{1'b1}}, {GAP_W{1'b0}}, {TAG_W{1'b1}}};

    typedef struct packed {
        logic [STATE_W-1:0] state;
        pick_mode_e         mode;
        logic [SEED_W-1:0]  seed_nxt;
    } top_s;

    top_s              t_d, t_q;
    logic              accept;
    logic              s_busy, s_fin, s_done;
    logic [TAG_W-1:0]  s_fin_tag, s_tag;
    logic [SEED_W-1:0] lf_seed;
    logic [OFS_W-1:0]  lf_ofs;
    logic [TAG_W-1:0]  start_tag;
    logic [OFS_W-1:0]  start_ofs;

    tagpick_lfsr #(
        .SEED_W (SEED_W),
        .OFS_W  (OFS_W)
    ) u_lfsr (
        .seed_i (t_q.state[STATE_W-1:SEED_LSB]),
        .seed_o (lf_seed),
        .ofs_o  (lf_ofs)
    );

    assign accept    = req_i && !s_busy;
    assign start_tag = mode_i ? add_start_i : t_q.state[TAG_W-1:0];
    assign start_ofs = mode_i ? add_ofs_i   : lf_ofs;

    tagpick_search #(
        .TAG_W (TAG_W),
        .OFS_W (OFS_W)
    ) u_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (accept),
        .start_tag_i (start_tag),
        .ofs_i       (start_ofs),
        .mask_i      (excl_req_i | excl_glb_i),
        .busy_o      (s_busy),
        .fin_o       (s_fin),
        .fin_tag_o   (s_fin_tag),
        .done_o      (s_done),
        .tag_o       (s_tag)
    );

    always_comb begin
        t_d = t_q;
        if (accept) begin
            t_d.mode     = pick_mode_e'(mode_i);
            t_d.seed_nxt = lf_seed;
        end else if (st_wr_i && !s_busy) begin
            t_d.state = st_wdata_i & WR_MASK;
        end
        if (s_fin && t_q.mode == PICK_RAND) begin
            t_d.state = {t_q.seed_nxt, {GAP_W{1'b0}}, s_fin_tag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o  = s_busy;
    assign done_o  = s_done;
    assign tag_o   = s_tag;
    assign state_o = t_q.state;

endmodule

// File: rtl/tag_pick_unit_chk.sv
module tag_pick_unit_chk #(
    parameter int TAG_W    = 4,
    parameter int OFS_W    = 4,
    parameter int SEED_LSB = 8,
    parameter int STATE_W  = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_i,
    input logic                  mode_i,
    input logic [(1<<TAG_W)-1:0] excl_req_i,
    input logic [(1<<TAG_W)-1:0] excl_glb_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [TAG_W-1:0]      tag_o,
    input logic [STATE_W-1:0]    state_o
);

    localparam int NTAGS = 1 << TAG_W;
    localparam int LIMIT = (1 << OFS_W) * NTAGS + 1;

    logic [NTAGS-1:0]   mask_c;
    logic               mode_c;
    logic [STATE_W-1:0] state_c;
    int unsigned        cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_c  <= '0;
            mode_c  <= 1'b0;
            state_c <= '0;
            cnt     <= 0;
        end else begin
            if (req_i && !busy_o) begin
                mask_c  <= excl_req_i | excl_glb_i;
                mode_c  <= mode_i;
                state_c <= state_o;
            end
            cnt <= busy_o ? cnt + 1 : 0;
        end
    end

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11
    search_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> cnt < LIMIT);
    // R3
    pick_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(&mask_c)) |-> !mask_c[tag_o]);
    // R4
    all_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (&mask_c)) |-> tag_o == '0);
    // R9
    add_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_c) |-> state_o == state_c);
    // R8
    rand_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_c) |->
            (state_o[TAG_W-1:0] == tag_o && state_o[SEED_LSB-1:TAG_W] == '0));
    // R10
    busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(state_o));

endmodule

bind tag_pick_unit tag_pick_unit_chk #(
    .TAG_W    (TAG_W),
    .OFS_W    (OFS_W),
    .SEED_LSB (SEED_LSB),
    .STATE_W  (SEED_LSB + SEED_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .mode_i     (mode_i),
    .excl_req_i (excl_req_i),
    .excl_glb_i (excl_glb_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .tag_o      (tag_o),
    .state_o    (state_o)
);

// File: tb/sim_tag_pick_unit.sv
`timescale 1ns/1ps
module sim_tag_pick_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [15:0] excl_req_i = '0;
    logic [15:0] excl_glb_i = '0;
    logic [3:0]  add_start_i = '0;
    logic [3:0]  add_ofs_i = '0;
    logic        st_wr_i = 1'b0;
    logic [23:0] st_wdata_i = '0;
    logic        busy_o, done_o;
    logic [3:0]  tag_o;
    logic [23:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] mstate = '0;

    always #2.5 clk = ~clk;

    tag_pick_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .excl_req_i(excl_req_i), .excl_glb_i(excl_glb_i),
        .add_start_i(add_start_i), .add_ofs_i(add_ofs_i),
        .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
        .busy_o(busy_o), .done_o(done_o), .tag_o(tag_o), .state_o(state_o)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // R6 R7 R4: walk from st, N advances, skipping excluded values
    function automatic logic [3:0] m_pick(logic [3:0] st, logic [3:0] ofs, logic [15:0] m);
        logic [3:0] t = st;
        if (m == 16'hFFFF) return 4'd0;
        if (ofs == 0) begin
            for (int k = 0; k < 16; k++) if (m[t]) t = t + 1'b1;
        end else begin
            for (int a = 0; a < int'(ofs); a++) begin
                t = t + 1'b1;
                for (int k = 0; k < 16; k++) if (m[t]) t = t + 1'b1;
            end
        end
        return t;
    endfunction

    // R5: returns {new seed, offset}
    function automatic logic [19:0] m_lfsr(logic [15:0] s);
        logic [3:0] o = '0;
        for (int i = 0; i < 4; i++) begin
            logic b = s[5] ^ s[3] ^ s[2] ^ s[0];
            s = {b, s[15:1]};
            o[i] = b;
        end
        return {s, o};
    endfunction

    task automatic do_write(logic [23:0] w);
        st_wr_i = 1'b1; st_wdata_i = w;
        @(negedge clk);
        st_wr_i = 1'b0;
        mstate = w & 24'hFFFF0F;
        check("R2 write", state_o, mstate);
    endtask

    task automatic do_req(logic md, logic [15:0] er, logic [15:0] eg,
                          logic [3:0] ast, logic [3:0] aof);
        logic [19:0] lf = m_lfsr(mstate[23:8]);
        logic [3:0]  exp_tag;
        int          w = 0;
        if (md) exp_tag = m_pick(ast, aof, er | eg);
        else    exp_tag = m_pick(mstate[3:0], lf[3:0], er | eg);
        req_i = 1'b1; mode_i = md; excl_req_i = er; excl_glb_i = eg;
        add_start_i = ast; add_ofs_i = aof;
        @(negedge clk);
        req_i = 1'b0;
        excl_req_i = $urandom; excl_glb_i = $urandom;
        while (!done_o && w < 400) begin
            @(negedge clk);
            w++;
        end
        if (w >= 400) check("R11 watchdog", 32'd0, 32'd1);
        check(md ? "R9/R7 tag" : "R5/R6/R7 tag", tag_o, exp_tag);
        if (!md) mstate = {lf[19:4], 4'h0, exp_tag};
        check(md ? "R9 state" : "R8 state", state_o, mstate);
        @(negedge clk);
        check("R11 done pulse", done_o, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        check("R1 state", state_o, 0);
        check("R1 tag", tag_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: bits [7:4] cleared on write
        do_write(24'h0001F5);
        check("R2 gap", state_o[7:4], 4'h0);
        // R5 R8: seed 0001 -> offset 1, seed 1000; start 5 -> tag 6
        do_req(1'b0, 16'h0, 16'h0, 4'h0, 4'h0);
        check("R5 directed tag", tag_o, 4'h6);
        check("R8 directed state", state_o, 24'h100006);
        // R6: offset 0, 3 and 4 excluded -> 5
        do_req(1'b1, 16'h0008, 16'h0010, 4'd3, 4'd0);
        check("R6 directed", tag_o, 4'd5);
        // R7: start 14, offset 2, 15 and 0 excluded -> 2
        do_req(1'b1, 16'h8000, 16'h0001, 4'd14, 4'd2);
        check("R7 directed wrap", tag_o, 4'd2);
        // R4: all excluded
        do_req(1'b1, 16'hFF00, 16'h00FF, 4'd9, 4'd5);
        check("R4 directed", tag_o, 4'd0);
        // R3: global mask alone excludes the start
        do_req(1'b1, 16'h0, 16'h0200, 4'd9, 4'd0);
        check("R3 global", tag_o, 4'd10);

        // R10 R11: long search, then refused request and write
        req_i = 1'b1; mode_i = 1'b1; excl_req_i = 16'hFF7F; excl_glb_i = 16'h0;
        add_start_i = 4'd0; add_ofs_i = 4'd15;
        @(negedge clk);
        check("R11 busy after accept", busy_o, 1'b1);
        req_i = 1'b1; mode_i = 1'b0; excl_req_i = 16'h0; add_ofs_i = 4'd1;
        st_wr_i = 1'b1; st_wdata_i = 24'hABCDEF;
        @(negedge clk);
        req_i = 1'b0; st_wr_i = 1'b0;
        begin
            int w = 0;
            while (!done_o && w < 400) begin
                @(negedge clk);
                w++;
            end
            if (w >= 400) check("R11 watchdog", 32'd0, 32'd1);
        end
        check("R10 refused tag", tag_o, 4'd7);
        check("R10 refused state", state_o, mstate);
        @(negedge clk);

        for (int it = 0; it < 300; it++) begin
            logic [15:0] er, eg;
            int sel = $urandom % 5;
            case (sel)
                0: begin er = '0; eg = '0; end
                1: begin er = $urandom; eg = '0; end
                2: begin er = $urandom | $urandom; eg = $urandom | $urandom; end
                3: begin er = ~(16'h1 << ($urandom % 16)); eg = '0; end
                default: begin er = $urandom & $urandom; eg = $urandom & $urandom; end
            endcase
            if (($urandom % 40) == 0) er = 16'hFFFF;
            if (($urandom % 6) == 0) do_write($urandom);
            do_req(1'($urandom), er, eg, 4'($urandom), 4'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #900000;
        n_chk++; n_bad++;
        $display("FAIL R11 global watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule